// File: doc/BRIEF.md
# Two-Wire Wiper Command Slave

This block is the serial front end of a one- or two-channel digital wiper controller. It watches the two-wire bus (clock and data) with a fast system clock, recognises start and stop conditions, and answers only to its own 7-bit address. The lower two bits of that address come from two strap inputs. It acknowledges bytes and returns read data through an open-drain enable: when `sda_oe` is high, the pad pulls the data line low.

A write transfer has three parts: the address byte, one instruction byte, and then any number of data bytes. The instruction byte chooses the channel and carries the midscale-reset, shutdown and two logic-output bits. These are passed on at once through a one-cycle command strobe. Each data byte that follows raises a one-cycle data strobe with the new wiper code, always for the channel last chosen. A read transfer has no instruction byte. It returns the code that the register block shows on `rd_code` for the channel last chosen, one byte for each master acknowledge. A master not-acknowledge ends the read.

The FSM has these states: IDLE, ADDR, ADDR_ACK, INSTR, INSTR_ACK, DATA, DATA_ACK, READ, READ_ACK and IGNORE. A start moves the FSM to ADDR from any state, and a stop moves it to IDLE. From ADDR, a completed byte goes to ADDR_ACK on an address match or to IGNORE on a mismatch. From ADDR_ACK, the SCL fall goes to READ or INSTR, as the R/W bit says. INSTR goes to INSTR_ACK, INSTR_ACK goes to DATA, and DATA and DATA_ACK alternate. READ goes to READ_ACK. From READ_ACK, a master ACK returns to READ and a NACK goes to IGNORE.

Top module: `i2cw_slave`

## Requirements
- R1: After reset, `sda_oe`, `cmd_stb` and `data_stb` are low and `chan_sel` is 0.
- R2: The slave address is {01011, strap_a1, strap_a0}, sent MSB first, followed by R/W (bit 0: 1 = read). On a match, the slave pulls SDA low for the ninth clock.
- R3: On an address mismatch, the slave drives nothing and raises no strobe until the next start.
- R4: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop in the middle of a byte discards that byte, and the next start begins a new transfer.
- R5: `sda_oe` changes only while SCL is low. An acknowledge is released after the falling edge of the ninth clock.
- R6: The instruction byte is decoded as bit 7 = channel (0 = first, 1 = second), bit 6 = midscale reset, bit 5 = shutdown, bit 4 = out1 and bit 3 = out2. Bits 2..0 are ignored. A one-cycle `cmd_stb` carries these fields once the byte is acknowledged.
- R7: Every data byte of a write, however many follow the instruction, gives one one-cycle `data_stb` with `data_code` equal to the byte.
- R8: In a read, the byte after the address acknowledge is `rd_code`, sent MSB first. A master ACK sends the byte again, and a master NACK ends the transfer.
- R9: `chan_sel` holds the channel of the last accepted instruction and changes only with `cmd_stb`. An instruction followed by a repeated start and a read returns the newly chosen channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | Pull data line low when high |
| strap_a1 | input | 1 | Address strap, address bit 1 |
| strap_a0 | input | 1 | Address strap, address bit 0 |
| rd_code | input | 8 | Code of selected channel from register block |
| chan_sel | output | 1 | Channel last selected |
| cmd_stb | output | 1 | Instruction accepted strobe |
| cmd_chan | output | 1 | Instruction channel |
| cmd_midscale | output | 1 | Midscale reset request |
| cmd_shutdown | output | 1 | Shutdown request |
| cmd_out1 | output | 1 | Logic output 1 level |
| cmd_out2 | output | 1 | Logic output 2 level |
| data_stb | output | 1 | Data byte strobe |
| data_code | output | 8 | New wiper code |

## Verification
A write with two data bytes to the second channel shows whether repeated data bytes are kept apart. A later read with master ACK then NACK checks that readback follows the chosen channel and that ACK continues the read while NACK ends it. An instruction with random low bits, followed by a repeated start and a read, checks that the don't-care bits are masked and that the channel switch takes effect. A mismatched address and a stop in the middle of an instruction check that nothing is acknowledged or strobed. A fresh write afterwards checks that the slave recovers.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_IGNORE
    } wst_e;

    typedef struct packed {
        logic chan;
        logic midscale;
        logic shutdown;
        logic out1;
        logic out2;
    } instr_t;

    localparam int INSTR_CHAN_BIT = 7;
    localparam int INSTR_MID_BIT  = 6;
    localparam int INSTR_SHD_BIT  = 5;
    localparam int INSTR_O1_BIT   = 4;
    localparam int INSTR_O2_BIT   = 3;

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain[0] <= scl_i;
                    sda_chain[0] <= sda_i;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[STAGES-2:0], scl_i};
                    sda_chain <= {sda_chain[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_chain[STAGES-1];
            sda_q <= sda_chain[STAGES-1];
        end
    end

    assign scl_s     = scl_chain[STAGES-1];
    assign sda_s     = sda_chain[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cw_fsm.sv
module i2cw_fsm
    import i2cw_pkg::*;
#(
    parameter int          BYTE_BITS = 8,
    parameter logic [4:0]  ADDR_HI   = 5'b01011
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sda_s,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic                 strap_a1,
    input  logic                 strap_a0,
    input  logic [BYTE_BITS-1:0] rd_code,
    output logic                 sda_oe,
    output logic                 instr_stb,
    output logic [BYTE_BITS-1:0] instr_byte,
    output logic                 dbyte_stb,
    output logic [BYTE_BITS-1:0] dbyte
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);

    wst_e                 state_q;
    wst_e                 state_d;
    logic [CNT_W-1:0]     bit_cnt;
    logic [BYTE_BITS-1:0] shreg;
    logic                 mack_q;
    logic                 byte_done;
    logic                 addr_hit;
    logic                 receiving;

    assign byte_done = scl_fall && (bit_cnt == CNT_W'(BYTE_BITS));
    assign addr_hit  = (shreg[BYTE_BITS-1:1] == {ADDR_HI, strap_a1, strap_a0});
    assign receiving = (state_q == ST_ADDR) || (state_q == ST_INSTR) ||
                       (state_q == ST_DATA);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall)  state_d = shreg[0] ? ST_READ : ST_INSTR;
                ST_INSTR:     if (byte_done) state_d = ST_INSTR_ACK;
                ST_INSTR_ACK: if (scl_fall)  state_d = ST_DATA;
                ST_DATA:      if (byte_done) state_d = ST_DATA_ACK;
                ST_DATA_ACK:  if (scl_fall)  state_d = ST_DATA;
                ST_READ:      if (byte_done) state_d = ST_READ_ACK;
                ST_READ_ACK:  if (scl_fall)  state_d = mack_q ? ST_READ : ST_IGNORE;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // bit counter, shift register and master acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            mack_q  <= 1'b0;
        end else begin
            if (state_d != state_q) begin
                bit_cnt <= '0;
            end else if (scl_rise && (receiving || state_q == ST_READ)) begin
                bit_cnt <= bit_cnt + 1'b1;
            end

            if (receiving && scl_rise) begin
                shreg <= {shreg[BYTE_BITS-2:0], sda_s};
            end else if (state_d == ST_READ && state_q != ST_READ) begin
                shreg <= rd_code;
            end else if (state_q == ST_READ && scl_fall && !byte_done) begin
                shreg <= {shreg[BYTE_BITS-2:0], 1'b1};
            end

            if (state_q == ST_READ_ACK && scl_rise) begin
                mack_q <= ~sda_s;
            end
        end
    end

    // registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_stb  <= 1'b0;
            instr_byte <= '0;
            dbyte_stb  <= 1'b0;
            dbyte      <= '0;
        end else begin
            instr_stb <= (state_q == ST_INSTR) && (state_d == ST_INSTR_ACK);
            dbyte_stb <= (state_q == ST_DATA)  && (state_d == ST_DATA_ACK);
            if ((state_q == ST_INSTR) && (state_d == ST_INSTR_ACK)) instr_byte <= shreg;
            if ((state_q == ST_DATA)  && (state_d == ST_DATA_ACK))  dbyte      <= shreg;
        end
    end

    // open-drain drive
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_INSTR_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            ST_READ:                                sda_oe = ~shreg[BYTE_BITS-1];
            default:                                sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2cw_decode.sv
module i2cw_decode
    import i2cw_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_stb,
    input  logic [BYTE_BITS-1:0] instr_byte,
    input  logic                 dbyte_stb,
    input  logic [BYTE_BITS-1:0] dbyte,
    output logic                 chan_sel,
    output logic                 cmd_stb,
    output instr_t               cmd,
    output logic                 data_stb,
    output logic [BYTE_BITS-1:0] data_code
);
    instr_t fields;

    generate
        if (NUM_CH > 1) begin : g_dual
            assign fields.chan = instr_byte[INSTR_CHAN_BIT];
        end else begin : g_single
            assign fields.chan = 1'b0;
        end
    endgenerate

    assign fields.midscale = instr_byte[INSTR_MID_BIT];
    assign fields.shutdown = instr_byte[INSTR_SHD_BIT];
    assign fields.out1     = instr_byte[INSTR_O1_BIT];
    assign fields.out2     = instr_byte[INSTR_O2_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_sel  <= 1'b0;
            cmd_stb   <= 1'b0;
            cmd       <= '0;
            data_stb  <= 1'b0;
            data_code <= '0;
        end else begin
            cmd_stb  <= instr_stb;
            data_stb <= dbyte_stb;
            if (instr_stb) begin
                cmd      <= fields;
                chan_sel <= fields.chan;
            end
            if (dbyte_stb) data_code <= dbyte;
        end
    end

endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave
    import i2cw_pkg::*;
#(
    parameter int         NUM_CH      = 2,
    parameter int         SYNC_STAGES = 2,
    parameter int         BYTE_BITS   = 8,
    parameter logic [4:0] ADDR_HI     = 5'b01011
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe,
    input  logic                 strap_a1,
    input  logic                 strap_a0,
    input  logic [BYTE_BITS-1:0] rd_code,
    output logic                 chan_sel,
    output logic                 cmd_stb,
    output logic                 cmd_chan,
    output logic                 cmd_midscale,
    output logic                 cmd_shutdown,
    output logic                 cmd_out1,
    output logic                 cmd_out2,
    output logic                 data_stb,
    output logic [BYTE_BITS-1:0] data_code
);
    logic                 scl_sync;
    logic                 sda_sync;
    logic                 scl_rise;
    logic                 scl_fall;
    logic                 start_det;
    logic                 stop_det;
    logic                 instr_stb;
    logic [BYTE_BITS-1:0] instr_byte;
    logic                 dbyte_stb;
    logic [BYTE_BITS-1:0] dbyte;
    instr_t               cmd;

    i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_sync),
        .sda_s     (sda_sync),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cw_fsm #(.BYTE_BITS(BYTE_BITS), .ADDR_HI(ADDR_HI)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_sync),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .strap_a1   (strap_a1),
        .strap_a0   (strap_a0),
        .rd_code    (rd_code),
        .sda_oe     (sda_oe),
        .instr_stb  (instr_stb),
        .instr_byte (instr_byte),
        .dbyte_stb  (dbyte_stb),
        .dbyte      (dbyte)
    );

    i2cw_decode #(.NUM_CH(NUM_CH), .BYTE_BITS(BYTE_BITS)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_stb  (instr_stb),
        .instr_byte (instr_byte),
        .dbyte_stb  (dbyte_stb),
        .dbyte      (dbyte),
        .chan_sel   (chan_sel),
        .cmd_stb    (cmd_stb),
        .cmd        (cmd),
        .data_stb   (data_stb),
        .data_code  (data_code)
    );

    assign cmd_chan     = cmd.chan;
    assign cmd_midscale = cmd.midscale;
    assign cmd_shutdown = cmd.shutdown;
    assign cmd_out1     = cmd.out1;
    assign cmd_out2     = cmd.out2;

endmodule

// File: rtl/i2cw_slave_chk.sv
module i2cw_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_sync,
    input logic sda_oe,
    input logic cmd_stb,
    input logic data_stb,
    input logic chan_sel
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_sync);                       // R5

    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);                                           // R6

    AST_DATA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |=> !data_stb);                                         // R7

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_stb && data_stb));                                         // R7

    AST_SEL_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel != $past(chan_sel)) |-> cmd_stb);                      // R9

endmodule

bind i2cw_slave i2cw_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_sync (scl_sync),
    .sda_oe   (sda_oe),
    .cmd_stb  (cmd_stb),
    .data_stb (data_stb),
    .chan_sel (chan_sel)
);

// File: tb/i2cw_slave_test.sv
`timescale 1ns/1ps
module i2cw_slave_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       sda_bus;
    logic [7:0] rd_code;
    logic       chan_sel, cmd_stb, cmd_chan, cmd_midscale, cmd_shutdown, cmd_out1, cmd_out2;
    logic       data_stb;
    logic [7:0] data_code;
    logic [7:0] regs [2];
    logic [8:0] exp_q [$];
    logic       oe_prev = 1'b0;
    int         n_chk = 0;
    int         n_bad = 0;
    int         oe_violations = 0;
    bit         done = 1'b0;

    localparam int Q = 50;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2cw_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .strap_a1(1'b1), .strap_a0(1'b0), .rd_code(rd_code), .chan_sel(chan_sel),
        .cmd_stb(cmd_stb), .cmd_chan(cmd_chan), .cmd_midscale(cmd_midscale),
        .cmd_shutdown(cmd_shutdown), .cmd_out1(cmd_out1), .cmd_out2(cmd_out2),
        .data_stb(data_stb), .data_code(data_code)
    );

    // register block model fed by the strobes
    always @(posedge clk) begin
        if (!rst_n) begin
            regs[0] <= 8'h80;
            regs[1] <= 8'h80;
        end else if (data_stb) begin
            regs[chan_sel] <= data_code;
        end
    end
    assign rd_code = regs[chan_sel];

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_stb) begin
                logic [8:0] e;
                logic [8:0] a;
                a = {1'b1, cmd_chan, cmd_midscale, cmd_shutdown, cmd_out1, cmd_out2, 3'b000};
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected cmd_stb", 16'(a), 16'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(a == e, "R6 command fields", 16'(a), 16'(e));
                end
            end
            if (data_stb) begin
                logic [8:0] e;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected data_stb", 16'(data_code), 16'h0);
                end else begin
                    e = exp_q.pop_front();
                    check({1'b0, data_code} == e, "R7 data byte", 16'(data_code), 16'(e));
                end
            end
            if (sda_oe != oe_prev && scl_m) oe_violations++;
            oe_prev <= sda_oe;
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; ack = ~sda_bus; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #Q; scl_m = 1'b1; #Q; b[i] = sda_bus; #Q; scl_m = 1'b0;
        end
        #Q; sda_m = nack; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q; sda_m = 1'b1;
    endtask

    // driver: writes push expected strobes
    task automatic write_instr(input logic [7:0] ins);
        bit ack;
        send_byte(ins, ack);
        check(ack, "R6 instruction ack", 16'(ack), 16'd1);
    endtask

    initial begin
        bit         ack;
        logic [7:0] rb;
        #1;
        #20;
        check(sda_oe == 1'b0 && cmd_stb == 1'b0 && data_stb == 1'b0, "R1 reset outputs",
              16'({sda_oe, cmd_stb, data_stb}), 16'h0);
        check(chan_sel == 1'b0, "R1 reset chan_sel", 16'(chan_sel), 16'h0);
        rst_n = 1'b1;
        #100;

        // write: channel 2, out1 set, two data bytes
        bus_start();
        send_byte(8'h5C, ack);
        check(ack, "R2 address ack on match", 16'(ack), 16'd1);
        exp_q.push_back({1'b1, 8'h90});
        write_instr(8'h90);
        exp_q.push_back({1'b0, 8'hA5});
        send_byte(8'hA5, ack);
        check(ack, "R7 first data ack", 16'(ack), 16'd1);
        exp_q.push_back({1'b0, 8'h3C});
        send_byte(8'h3C, ack);
        check(ack, "R7 repeated data ack", 16'(ack), 16'd1);
        bus_stop();
        #100;
        check(chan_sel == 1'b1, "R9 chan_sel after write", 16'(chan_sel), 16'd1);

        // read: ACK then NACK
        bus_start();
        send_byte(8'h5D, ack);
        check(ack, "R2 read address ack", 16'(ack), 16'd1);
        recv_byte(1'b0, rb);
        check(rb == 8'h3C, "R8 read byte 1", 16'(rb), 16'h3C);
        recv_byte(1'b1, rb);
        check(rb == 8'h3C, "R8 read byte 2 after master ack", 16'(rb), 16'h3C);
        bus_stop();
        #100;
        check(sda_oe == 1'b0, "R8 released after nack", 16'(sda_oe), 16'h0);

        // instruction with don't-care bits, repeated start, read channel 1
        bus_start();
        send_byte(8'h5C, ack);
        exp_q.push_back({1'b1, 8'h68});
        write_instr(8'h6F);
        sda_m = 1'b1; #Q;
        bus_start();
        send_byte(8'h5D, ack);
        check(ack, "R9 read after repeated start ack", 16'(ack), 16'd1);
        recv_byte(1'b1, rb);
        check(rb == 8'h80, "R9 readback of new channel", 16'(rb), 16'h80);
        bus_stop();
        #100;
        check(chan_sel == 1'b0, "R9 chan_sel switched", 16'(chan_sel), 16'h0);

        // wrong address: strap a1 mismatched
        bus_start();
        send_byte(8'h58, ack);
        check(!ack, "R3 no ack on mismatch", 16'(ack), 16'd0);
        send_byte(8'h90, ack);
        check(!ack, "R3 following byte ignored", 16'(ack), 16'd0);
        send_byte(8'h77, ack);
        check(!ack, "R3 data byte ignored", 16'(ack), 16'd0);
        bus_stop();
        #100;
        check(chan_sel == 1'b0, "R3 chan_sel untouched", 16'(chan_sel), 16'h0);

        // stop in the middle of an instruction
        bus_start();
        send_byte(8'h5C, ack);
        send_bits(8'hF0, 4);
        bus_stop();
        #100;
        check(chan_sel == 1'b0, "R4 aborted instruction discarded", 16'(chan_sel), 16'h0);

        // recovery write on channel 1 then read
        bus_start();
        send_byte(8'h5C, ack);
        check(ack, "R4 ack after abort", 16'(ack), 16'd1);
        exp_q.push_back({1'b1, 8'h00});
        write_instr(8'h00);
        exp_q.push_back({1'b0, 8'h11});
        send_byte(8'h11, ack);
        bus_stop();
        bus_start();
        send_byte(8'h5D, ack);
        recv_byte(1'b1, rb);
        check(rb == 8'h11, "R4 readback after recovery", 16'(rb), 16'h11);
        bus_stop();
        #200;

        check(exp_q.size() == 0, "R7 all expected strobes seen", 16'(exp_q.size()), 16'h0);
        check(oe_violations == 0, "R5 sda_oe stable while SCL high", 16'(oe_violations), 16'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #1000000;
                check(1'b0, "watchdog expired", 16'h0, 16'h1);
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule